// File: doc/BRIEF.md
# Eight-Level Interrupt Status Core

This block holds the request, in-service and mask state of an eight-level interrupt controller. It also gives a processor read access to that state over a simple bus slave. The slave has a chip select, read and write strobes, one address bit and an 8-bit data bus. Requests arrive already conditioned, as one-cycle set pulses per level. An acknowledge strobe moves the winning request into service. A decoded end-of-interrupt pulse retires the most urgent level in service.

A write with the address bit low and bits 4:3 equal to `01` is a control word. It can choose whether later low-address reads show the pending requests or the in-service levels, and that choice persists. It can also arm a poll. An armed poll turns the next low-address read into an acknowledge that returns the winning level. The mask is always read and written at the high address.

All bus actions are sampled on the rising clock edge. A read event is any cycle with `cs_n` and `rd_n` both low. A write event is any cycle with `cs_n` and `wr_n` both low. Read data is combinational and is zero outside a read event.

Top module: `irq_status_core`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, low-address reads show the pending register, no poll is armed and `int_out` is low.
- R2: A high bit of `req` sets the matching pending bit on the next edge whatever the mask holds; masking never clears pending bits.
- R3: A write event with `a0`=1 loads the mask from `din`; a read event with `a0`=1 drives the mask on `dout`, regardless of the readback choice or an armed poll, and leaves an armed poll armed.
- R4: A write event with `a0`=0 is a control word only when `din[4:3]`=`01`; then `din[1]`=1 sets the readback choice to `din[0]` (0 pending, 1 in-service) and `din[1]`=0 leaves it unchanged. Other low-address writes change nothing.
- R5: The readback choice holds across any number of reads until a control word with `din[1]`=1 changes it.
- R6: Level 0 is most urgent and level 7 least. The candidate is the lowest unmasked pending level. It is eligible when no in-service bit is set at its own or a lower index. `int_out` is high exactly when a candidate is eligible.
- R7: When `ack` is high and a candidate is eligible, the next edge sets its in-service bit and clears its pending bit. With no eligible candidate, `ack` changes nothing. A pending bit set and cleared on the same edge ends cleared.
- R8: A control word with `din[2]`=1 arms a poll, overriding the readback choice. The next read event with `a0`=0 returns `{eligible, 4'b0000, level}` (all zero when nothing is eligible), acts as an acknowledge and disarms the poll. A control word with `din[2]`=0 disarms it.
- R9: An `eoi` pulse clears the lowest-index set in-service bit on the next edge; with no bit set it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when no read event |
| req | input | 8 | Per-level request set pulses |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| int_out | output | 1 | Interrupt pending to the processor |

## Verification
The bench targets the readback choice persisting across repeated reads and surviving a control word that leaves the choice bit clear. A design that reselected on every control word would show the wrong register after such a write. Poll reads are checked with and without a pending level, and interleaved with mask reads. A design that consumed the poll on a mask read, or that did not acknowledge on the poll read, would show the wrong in-service bits afterwards. Priority blocking by an in-service level of equal or higher urgency is checked, along with acknowledge and end-of-interrupt when there is nothing to act on. Getting these wrong gives a spurious `int_out` or a corrupted in-service register.

// File: rtl/irq_status_core.sv
module irq_status_core #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         a0,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout,
  input  logic [N-1:0] req,
  input  logic         ack,
  input  logic         eoi,
  output logic         int_out
);
  localparam int LW = $clog2(N);

  logic [N-1:0] irr_q, isr_q, imr_q;
  logic         sel_isr_q, poll_q;

  function automatic logic [LW:0] first_set(input logic [N-1:0] v);
    logic [LW:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, LW'(i)};
    return r;
  endfunction

  logic          rd_evt, wr_evt, ctrl_wr, poll_rd, take, elig;
  logic [LW:0]   cand_f, serv_f;
  logic [LW-1:0] c_idx, s_idx;
  logic [N-1:0]  take_mask, eoi_mask;

  assign rd_evt  = !cs_n && !rd_n;
  assign wr_evt  = !cs_n && !wr_n;
  assign ctrl_wr = wr_evt && !a0 && din[4:3] == 2'b01;
  assign poll_rd = rd_evt && !a0 && poll_q;

  assign cand_f = first_set(irr_q & ~imr_q);
  assign serv_f = first_set(isr_q);
  assign c_idx  = cand_f[LW-1:0];
  assign s_idx  = serv_f[LW-1:0];
  assign elig   = cand_f[LW] && !(serv_f[LW] && s_idx <= c_idx);

  assign take      = elig && (ack || poll_rd);
  assign take_mask = take ? (N'(1) << c_idx) : '0;
  assign eoi_mask  = (eoi && serv_f[LW]) ? (N'(1) << s_idx) : '0;

  assign int_out = elig;

  always_comb begin
    dout = '0;
    if (rd_evt) begin
      if (a0)          dout = imr_q;
      else if (poll_q) dout = {elig, {(N-LW-1){1'b0}}, elig ? c_idx : {LW{1'b0}}};
      else if (sel_isr_q) dout = isr_q;
      else             dout = irr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      irr_q <= (irr_q | req) & ~take_mask;
      isr_q <= (isr_q & ~eoi_mask) | take_mask;
      if (wr_evt && a0) imr_q <= din;
      if (ctrl_wr && din[1]) sel_isr_q <= din[0];
      if (ctrl_wr) poll_q <= din[2];
      else if (poll_rd) poll_q <= 1'b0;
    end
  end
endmodule

module irq_status_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       a0,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic       ack,
  input logic       eoi,
  input logic       int_out,
  input logic [7:0] irr_q,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q,
  input logic       sel_isr_q,
  input logic       poll_q
);
  logic rd_evt, wr_evt, ctrl_wr;
  assign rd_evt  = !cs_n && !rd_n;
  assign wr_evt  = !cs_n && !wr_n;
  assign ctrl_wr = wr_evt && !a0 && din[4:3] == 2'b01;

  // R3
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && a0) |-> dout == imr_q);

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && din[1]) |=> $stable(sel_isr_q));

  // R6
  int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q & ~imr_q) != 8'h00);

  // R7
  ack_sets_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !eoi) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);

  // R7
  no_spurious_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !(rd_evt && !a0 && poll_q)) |=> (isr_q & ~$past(isr_q)) == 8'h00);

  // R8
  poll_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !a0 && poll_q && !ctrl_wr) |=> !poll_q);

  // R9
  eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !(rd_evt && !a0 && poll_q) && isr_q != 8'h00)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

bind irq_status_core irq_status_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
  .din(din), .dout(dout), .ack(ack), .eoi(eoi), .int_out(int_out),
  .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q), .sel_isr_q(sel_isr_q),
  .poll_q(poll_q)
);

// File: tb/test_irq_status_core.sv
`timescale 1ns/1ps
module test_irq_status_core;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0, ack = 0, eoi = 0;
  logic [7:0] din = 0, req = 0;
  logic [7:0] dout;
  logic int_out;
  int checks = 0, failures = 0;

  bit [7:0] m_irr, m_isr, m_imr;
  bit m_sel, m_poll;

  always #2.5 clk = ~clk;

  irq_status_core i_irq_status_core (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout), .req(req), .ack(ack), .eoi(eoi), .int_out(int_out)
  );

  function automatic int lowest(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int winner();
    int h, s;
    h = lowest(m_irr & ~m_imr);
    s = lowest(m_isr);
    if (h >= 0 && (s < 0 || s > h)) return h;
    return -1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int w;
    bit rd, wr, prd, ctl;
    bit [7:0] ed;
    #1;
    w  = winner();
    rd = !cs_n && !rd_n;
    wr = !cs_n && !wr_n;
    check("R6 int_out", {7'b0, int_out}, {7'b0, w >= 0});
    ed = 8'h00;
    if (rd) begin
      if (a0) ed = m_imr;
      else if (m_poll) ed = (w >= 0) ? (8'h80 | 8'(w)) : 8'h00;
      else ed = m_sel ? m_isr : m_irr;
    end
    check(tag, dout, ed);
    @(posedge clk);
    prd = rd && !a0 && m_poll;
    ctl = wr && !a0 && din[4:3] == 2'b01;
    begin
      bit [7:0] tk, ek;
      int s;
      tk = 0; ek = 0;
      if (w >= 0 && (ack || prd)) tk[w] = 1;
      s = lowest(m_isr);
      if (eoi && s >= 0) ek[s] = 1;
      m_irr = (m_irr | req) & ~tk;
      m_isr = (m_isr & ~ek) | tk;
      if (wr && a0) m_imr = din;
      if (ctl && din[1]) m_sel = din[0];
      if (ctl) m_poll = din[2];
      else if (prd) m_poll = 0;
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1; wr_n = 1; a0 = 0; din = 0; req = 0; ack = 0; eoi = 0;
  endtask

  task automatic wr(bit a, bit [7:0] d);
    cs_n = 0; wr_n = 0; a0 = a; din = d;
    cyc("bus write");
  endtask

  task automatic rd(bit a, bit [7:0] exp, string tag);
    cs_n = 0; rd_n = 0; a0 = a;
    #1 check(tag, dout, exp);
    cyc(tag);
  endtask

  task automatic pulse_req(bit [7:0] v); req = v; cyc("R2 req"); endtask
  task automatic do_ack(); ack = 1; cyc("R7 ack"); endtask
  task automatic do_eoi(); eoi = 1; cyc("R9 eoi"); endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    m_irr = 0; m_isr = 0; m_imr = 0; m_sel = 0; m_poll = 0;
    // R1 reset state
    check("R1 int_out", {7'b0, int_out}, 8'h00);
    rd(0, 8'h00, "R1 pending after reset");
    rd(1, 8'h00, "R1 mask after reset");
    // R2 masked requests still latch
    wr(1, 8'hFF);
    pulse_req(8'h24);
    rd(0, 8'h24, "R2 pending ignores mask");
    check("R6 masked no int", {7'b0, int_out}, 8'h00);
    rd(1, 8'hFF, "R3 mask readback");
    wr(1, 8'h00);
    check("R6 int when unmasked", {7'b0, int_out}, 8'h01);
    // R7 acknowledge takes level 2
    do_ack();
    wr(0, 8'h0B);
    rd(0, 8'h04, "R7 in-service after ack");
    rd(0, 8'h04, "R5 choice persists");
    check("R6 blocked by service", {7'b0, int_out}, 8'h00);
    // R4 control word without select bit, and non-control write
    wr(0, 8'h08);
    rd(0, 8'h04, "R4 RR clear keeps choice");
    wr(0, 8'h03);
    rd(0, 8'h04, "R4 non-control write ignored");
    pulse_req(8'h02);
    check("R6 higher level eligible", {7'b0, int_out}, 8'h01);
    do_ack();
    rd(0, 8'h06, "R7 nested service");
    // R9 end of interrupt
    do_eoi();
    rd(0, 8'h04, "R9 lowest index retired");
    do_eoi();
    rd(0, 8'h00, "R9 second retire");
    do_eoi();
    rd(0, 8'h00, "R9 eoi with nothing in service");
    // R8 poll
    wr(0, 8'h0F);
    rd(1, 8'h00, "R3 mask read during armed poll");
    rd(0, 8'h85, "R8 poll word");
    rd(0, 8'h20, "R8 poll acknowledged");
    wr(0, 8'h0A);
    rd(0, 8'h00, "R8 pending cleared by poll");
    wr(0, 8'h0C);
    rd(0, 8'h00, "R8 poll with nothing pending");
    wr(0, 8'h0B);
    rd(0, 8'h20, "R8 poll disarmed");
    do_ack();
    rd(0, 8'h20, "R7 ack with nothing eligible");
    // R2 masked request
    wr(1, 8'h01);
    pulse_req(8'h01);
    wr(0, 8'h0A);
    rd(0, 8'h01, "R2 masked level latched");
    check("R6 masked level no int", {7'b0, int_out}, 8'h00);
    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 4);
      if (op == 1) begin cs_n = 0; rd_n = 0; a0 = $urandom_range(0, 3) == 0; end
      if (op == 2) begin
        cs_n = 0; wr_n = 0; a0 = $urandom_range(0, 3) == 0;
        din = 8'($urandom);
        if ($urandom_range(0, 1) == 1) din[4:3] = 2'b01;
      end
      if ($urandom_range(0, 3) == 0) req = 8'(1 << $urandom_range(0, 7));
      ack = $urandom_range(0, 5) == 0;
      eoi = $urandom_range(0, 5) == 0;
      cyc("R3/R5/R8 random read");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule